// File: doc/BRIEF.md
# Ping-Pong Slot Delay Line

This block delays a continuous stream of samples by exactly one time slot. A frame is a fixed number of slots, and a slot is a fixed number of samples. The delay is built from two storage banks, each one slot deep, instead of one memory sized for a whole frame. With the default sizes that is 2 x 2560 = 5120 sample words, where a frame-deep buffer would need 38,400.

While incoming samples fill one bank, the previous slot is read out of the other bank in sample order. The two banks trade roles at every slot boundary. Neither side ever waits, so the output runs as continuously as the input once one slot has been collected.

A frame-start pulse realigns the block. A mid-slot gap in the input valid freezes both the fill position and the drain position, so the one-slot alignment survives the gap. Everything runs on a single clock.

Top module: `slot_delay_pp`

## Requirements
- R1: While reset is held, and on the first clock after reset, `out_valid` and `out_slot_start` are low.
- R2: After reset, no output sample is marked valid while the first SLOT_LEN accepted samples are being collected.
- R3: Once a slot has been collected, each accepted input sample produces one output sample in the next clock cycle. That output sample is the input sample that was accepted exactly SLOT_LEN accepted samples earlier. In other words, output sample i of slot n equals input sample i of slot n-1.
- R4: The two banks swap roles at every slot boundary, including the boundary between frames when SLOTS_PER_FRAME is odd. In any cycle a bank is either written or read, never both. The delayed stream therefore stays correct and gap-free across frame boundaries.
- R5: `out_slot_start` is high exactly with output sample 0 of each delayed slot. It is low in every other cycle.
- R6: `out_slot_num` gives the position, 0 to SLOTS_PER_FRAME-1, of the delayed slot inside its frame. It is counted from the last frame start, and it wraps from SLOTS_PER_FRAME-1 back to 0.
- R7: In a cycle where `in_valid` is low, no output sample is valid, and neither the fill position nor the drain position advances.
- R8: `in_frame_start` is honoured whether or not `in_valid` is high. It discards all buffered data and restarts at sample 0 of slot 0. If `in_valid` is high in the same cycle, that sample becomes sample 0 of slot 0. Outputs stay invalid until a full slot has been collected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_data | input | SAMPLE_W | Input sample |
| in_frame_start | input | 1 | Realign to sample 0 of slot 0 |
| out_valid | output | 1 | Delayed sample is present this cycle |
| out_data | output | SAMPLE_W | Delayed sample |
| out_slot_start | output | 1 | First sample of a delayed slot |
| out_slot_num | output | SLOT_W | Slot index of the delayed sample within its frame |

## Verification
Some internal faults only show up after a delay. A bank select that fails to toggle, or a fill index that skips or wraps early, leaves the outputs looking normal for a while. The output then carries samples from the wrong slot or the wrong position, starting with the first sample read after the faulty boundary: at most one slot plus one cycle after the fault.

A priming flag that is set too early or too late shows up in the first slot after reset or after a frame start. It appears as `out_valid` rising before or after sample SLOT_LEN+1 has been accepted.

The delayed stream is compared sample by sample against a queue that is filled only from the requirements. The comparison runs through realignment pulses, input gaps and several odd-length frames.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Which bank is being filled; the other bank drains.
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic int unsigned safe_clog2(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pp_slot_seq.sv
module pp_slot_seq
  import pp_pkg::*;
#(
  parameter int unsigned SLOT_LEN        = 2560,
  parameter int unsigned SLOTS_PER_FRAME = 15,
  localparam int unsigned IDX_W  = safe_clog2(SLOT_LEN),
  localparam int unsigned SLOT_W = safe_clog2(SLOTS_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              restart,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [SLOT_W-1:0] cur_slot,
  output bank_e             cur_bank,
  output logic              cur_primed
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(SLOT_LEN - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_FRAME - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] slot_q;
  bank_e             bank_q;
  logic              primed_q;

  // Effective position this cycle: a restart overrides stored state.
  always_comb begin
    cur_idx    = restart ? '0     : idx_q;
    cur_slot   = restart ? '0     : slot_q;
    cur_bank   = restart ? BANK_A : bank_q;
    cur_primed = restart ? 1'b0   : primed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      slot_q   <= '0;
      bank_q   <= BANK_A;
      primed_q <= 1'b0;
    end else if (step) begin
      if (cur_idx == LAST_IDX) begin
        idx_q    <= '0;
        slot_q   <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        bank_q   <= bank_e'(~cur_bank);
        primed_q <= 1'b1;
      end else begin
        idx_q    <= cur_idx + 1'b1;
        slot_q   <= cur_slot;
        bank_q   <= cur_bank;
        primed_q <= cur_primed;
      end
    end else begin
      idx_q    <= cur_idx;
      slot_q   <= cur_slot;
      bank_q   <= cur_bank;
      primed_q <= cur_primed;
    end
  end

  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);

  a_r6_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST_SLOT);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(idx_q) && $stable(bank_q));
endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 2560,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Single port: one address, write has priority, read is registered.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    else if (rd_en) rdata <= mem[addr];
  end

  a_r4_single_port: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: rtl/slot_delay_pp.sv
module slot_delay_pp
  import pp_pkg::*;
#(
  parameter int unsigned SAMPLE_W        = 16,
  parameter int unsigned SLOT_LEN        = 2560,
  parameter int unsigned SLOTS_PER_FRAME = 15,
  localparam int unsigned IDX_W  = safe_clog2(SLOT_LEN),
  localparam int unsigned SLOT_W = safe_clog2(SLOTS_PER_FRAME)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_frame_start,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_slot_start,
  output logic [SLOT_W-1:0]   out_slot_num
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_FRAME - 1);

  logic [IDX_W-1:0]    cur_idx;
  logic [SLOT_W-1:0]   cur_slot;
  bank_e               cur_bank;
  logic                cur_primed;
  logic [1:0]          wr_en, rd_en;
  logic [SAMPLE_W-1:0] bank_q [2];
  bank_e               rd_bank_q;
  logic [SLOT_W-1:0]   prev_slot;
  logic                rd_go;

  pp_slot_seq #(
    .SLOT_LEN        (SLOT_LEN),
    .SLOTS_PER_FRAME (SLOTS_PER_FRAME)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .step       (in_valid),
    .restart    (in_frame_start),
    .cur_idx    (cur_idx),
    .cur_slot   (cur_slot),
    .cur_bank   (cur_bank),
    .cur_primed (cur_primed)
  );

  assign rd_go = in_valid && cur_primed;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign wr_en[b] = in_valid && (cur_bank == bank_e'(b));
    assign rd_en[b] = rd_go && (cur_bank != bank_e'(b));

    pp_bank #(
      .WIDTH (SAMPLE_W),
      .DEPTH (SLOT_LEN)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_en[b]),
      .rd_en (rd_en[b]),
      .addr  (cur_idx),
      .wdata (in_data),
      .rdata (bank_q[b])
    );
  end

  assign prev_slot = (cur_slot == '0) ? LAST_SLOT : cur_slot - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_slot_start <= 1'b0;
      out_slot_num   <= '0;
      rd_bank_q      <= BANK_A;
    end else begin
      out_valid      <= rd_go;
      out_slot_start <= rd_go && (cur_idx == '0);
      if (rd_go) begin
        out_slot_num <= prev_slot;
        rd_bank_q    <= bank_e'(~cur_bank);
      end
    end
  end

  assign out_data = bank_q[rd_bank_q];

  a_r7_no_out_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_restart_blanks: assert property (@(posedge clk) disable iff (rst)
    in_frame_start |=> !out_valid);

  a_r5_start_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_slot_start |-> out_valid);

  a_r6_num_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slot_num <= LAST_SLOT));

  a_r4_one_bank_each: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_en) <= 1 && $countones(rd_en) <= 1);
endmodule

// File: tb/slot_delay_pp_tb.sv
module slot_delay_pp_tb;
  localparam int W     = 16;
  localparam int SLOT  = 4;
  localparam int SLOTS = 3;
  localparam int SW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_frame_start = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_slot_start;
  logic [SW-1:0] out_slot_num;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [W-1:0] ref_q [$];
  int accepted = 0;
  logic [W-1:0] seq_val = 16'h0100;

  always #2.5 clk = ~clk;

  slot_delay_pp #(
    .SAMPLE_W        (W),
    .SLOT_LEN        (SLOT),
    .SLOTS_PER_FRAME (SLOTS)
  ) u_dut (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_frame_start (in_frame_start),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_slot_start (out_slot_start),
    .out_slot_num   (out_slot_num)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compute expectation, sample 1 ns after posedge.
  task automatic step(input logic v, input logic fs, input string tag);
    bit exp_v = 1'b0;
    logic [W-1:0] exp_d = '0;
    int p;
    @(negedge clk);
    in_valid       = v;
    in_frame_start = fs;
    in_data        = seq_val;
    if (fs) begin
      ref_q.delete();
      accepted = 0;
    end
    if (v) begin
      if (ref_q.size() == SLOT) begin
        exp_v = 1'b1;
        exp_d = ref_q.pop_front();
      end
      ref_q.push_back(seq_val);
      p = accepted - SLOT;
      accepted++;
      seq_val = seq_val + 16'h0013;
    end
    @(posedge clk);
    #1;
    check(tag, int'(out_valid), int'(exp_v), "out_valid");
    if (exp_v) begin
      check("R3", int'(out_data), int'(exp_d), "out_data");
      check("R5", int'(out_slot_start), int'((p % SLOT) == 0), "out_slot_start");
      check("R6", int'(out_slot_num), (p / SLOT) % SLOTS, "out_slot_num");
    end else begin
      check("R5", int'(out_slot_start), 0, "out_slot_start while invalid");
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_frame_start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(out_slot_start), 0, "out_slot_start in reset");
    @(negedge clk);
    rst = 1'b0;
    ref_q.delete();
    accepted = 0;
    @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0, "out_valid after reset");
  endtask

  task automatic t_first_slot();
    for (int i = 0; i < SLOT; i++) step(1'b1, 1'b0, "R2");
  endtask

  // Three odd-length frames back to back: bank parity must keep alternating (R4).
  task automatic t_stream();
    for (int i = 0; i < 3 * SLOTS * SLOT; i++) step(1'b1, 1'b0, "R4");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 45; i++) step((i % 3) != 1 && (i % 7) != 5, 1'b0, "R7");
  endtask

  task automatic t_frame_start();
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    for (int i = 0; i < 2 * SLOT + 3; i++) step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b1, "R8");
    for (int i = 0; i < 3 * SLOT; i++) step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    for (int i = 0; i < SLOTS * SLOT + 2; i++) step(i != 3, 1'b0, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_slot();
    t_stream();
    t_gaps();
    t_frame_start();
    t_reset();
    t_first_slot();
    t_gaps();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule